// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block turns the core clock into the serial clock of an SPI master. A prescale field from the configuration register selects the divisor. A build-time parameter chooses one of two ways to read that field. The legacy reading allows only even divisors from 4 to 30. The extended reading multiplies a 4-bit linear factor by a power of two, which reaches divisors from 1 to 1920. Software searches for the best field value. The block only decodes the field and counts.

While enabled, the block alternates a low phase and a high phase of the serial clock. It raises a one-cycle toggle strobe in the last core cycle of each phase. It also splits that strobe into a rising-edge indication and a falling-edge indication, so that the shifter can launch and capture on the same core edge where the serial clock changes. A period runs from one rising edge to the next. A new field value is taken up only at a rising edge, or at any time while the block is disabled, so a reprogrammed divisor never cuts a phase short.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: In legacy encoding, a field whose bit 4 is 1 and whose bits 3:0 hold k with k of 2 or more gives a divisor of 2k: k core cycles high and k core cycles low.
- R2: In legacy encoding, a field that would encode a divisor below 4 runs at divisor 4, with 2 cycles high and 2 low. Such a field has bit 4 at 0, or bits 3:0 below 2.
- R3: In extended encoding, the divisor is the linear factor in field bits 3:0 times 2 to the power of a 3-bit exponent. Exponent bit 0 is field bit 4, and exponent bits 2:1 are field bits 7:6. Field bit 5 has no effect. The largest divisor is 15 × 128 = 1920.
- R4: In extended encoding, a linear factor of 0 acts as a factor of 1.
- R5: For a divisor D of 2 or more, the high phase lasts ceil(D/2) core cycles and the low phase lasts floor(D/2). An even D therefore gives a 50% duty cycle, and an odd D gives the extra cycle to the high phase.
- R6: A divisor of 1 raises the toggle strobe in every enabled core cycle, so the serial clock changes at every core edge and runs at half the core rate.
- R7: The toggle strobe is high in a cycle exactly when the serial clock inverts at the next core edge. The rising indication equals the strobe while the serial clock is low. The falling indication equals the strobe while it is high. The two indications are never high together.
- R8: While the enable is low, all three strobes are low and the serial clock goes low at the next edge. After the enable rises, the first rising indication appears in the floor(D/2)-th enabled cycle (at least the first).
- R9: A field change while enabled leaves the phase in progress at its old length. The new divisor takes effect from the next rising edge of the serial clock.
- R10: During reset, the serial clock and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the serial clock; low holds it idle and low |
| presc_field | input | LIN_W+EXP_W+1 (8) | Prescale field from the configuration register |
| tick | output | 1 | Half-period toggle strobe |
| sclk | output | 1 | Serial clock, idle low |
| sclk_rise | output | 1 | The serial clock rises at the next core edge |
| sclk_fall | output | 1 | The serial clock falls at the next core edge |

## Verification
The three strobes are decoded from registered state and the enable, so they are due in the same cycle as the state that causes them. The serial clock itself changes one core edge after the strobe. A field change shows no effect until the next rising strobe, and then takes effect in the high phase that follows it. A drop of the enable removes the strobes in the same cycle and clears the serial clock one edge later. The bench drives inputs shortly after a rising edge and samples every output on the falling edge. On every clock it compares the outputs with a behavioural model. Phase-length measurements and enable-timing counts are taken from the same falling-edge samples, so each expected value lines up with the cycle where it is due.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

  // How the prescale field is interpreted
  typedef enum logic {
    ENC_LEGACY   = 1'b0,
    ENC_EXTENDED = 1'b1
  } presc_enc_e;

  // Level of the serial clock during the current phase
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } sclk_phase_e;

endpackage

// File: rtl/presc_decode.sv
module presc_decode
  import spi_presc_pkg::*;
#(
  parameter presc_enc_e ENC     = ENC_EXTENDED,
  parameter int         LIN_W   = 4,
  parameter int         EXP_W   = 3,
  parameter int         FIELD_W = LIN_W + EXP_W + 1,
  parameter int         DIV_W   = LIN_W + (1 << EXP_W) - 1
) (
  input  logic [FIELD_W-1:0] field,
  output logic [DIV_W-1:0]   divisor
);

  if (ENC == ENC_LEGACY) begin : g_legacy
    // Even divisors only: value 2*k when bit LIN_W is set, floor of 4
    function automatic logic [DIV_W-1:0] legacy_div(input logic [LIN_W:0] f);
      logic [DIV_W-1:0] d;
      d = {{(DIV_W-LIN_W-1){1'b0}}, f[LIN_W-1:0], 1'b0};
      if (!f[LIN_W] || (f[LIN_W-1:0] < LIN_W'(2)))
        d = DIV_W'(4);
      return d;
    endfunction

    logic unused_hi;
    assign unused_hi = ^field[FIELD_W-1:LIN_W+1];
    assign divisor   = legacy_div(field[LIN_W:0]);
  end else begin : g_extended
    // Linear factor times a power of two; exponent bits are split
    function automatic logic [DIV_W-1:0] ext_div(input logic [FIELD_W-1:0] f);
      logic [LIN_W-1:0] lin;
      logic [EXP_W-1:0] ex;
      lin = f[LIN_W-1:0];
      if (lin == '0)
        lin = LIN_W'(1);
      ex = {f[FIELD_W-1:LIN_W+2], f[LIN_W]};
      return DIV_W'(lin) << ex;
    endfunction

    logic unused_gap;
    assign unused_gap = field[LIN_W+1];
    assign divisor    = ext_div(field);
  end

endmodule

// File: rtl/presc_counter.sv
module presc_counter
  import spi_presc_pkg::*;
#(
  parameter int DIV_W   = 11,
  parameter int RST_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] next_div,
  output logic             tick,
  output logic             sclk,
  output logic             sclk_rise,
  output logic             sclk_fall,
  output logic [DIV_W-1:0] div_cur,
  output logic             reload
);

  // Longer half goes to the high phase
  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] s;
    s = {1'b0, d} + (DIV_W+1)'(1);
    return s[DIV_W:1];
  endfunction

  // Shorter half, never below one cycle
  function automatic logic [DIV_W-1:0] low_len(input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] h;
    h = d >> 1;
    if (h == '0)
      h = DIV_W'(1);
    return h;
  endfunction

  sclk_phase_e      ph_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] phase_len;
  logic             phase_end;

  assign phase_len = (ph_q == PH_HIGH) ? high_len(div_q) : low_len(div_q);
  assign phase_end = en && (cnt_q == phase_len - DIV_W'(1));
  assign reload    = !en || (phase_end && (ph_q == PH_LOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LOW;
      cnt_q <= '0;
      div_q <= DIV_W'(RST_DIV);
    end else begin
      if (!en) begin
        ph_q  <= PH_LOW;
        cnt_q <= '0;
      end else if (phase_end) begin
        ph_q  <= (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
      if (reload)
        div_q <= next_div;
    end
  end

  assign tick      = phase_end;
  assign sclk      = (ph_q == PH_HIGH);
  assign sclk_rise = phase_end && (ph_q == PH_LOW);
  assign sclk_fall = phase_end && (ph_q == PH_HIGH);
  assign div_cur   = div_q;

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import spi_presc_pkg::*;
#(
  parameter presc_enc_e ENC   = ENC_EXTENDED,
  parameter int         LIN_W = 4,
  parameter int         EXP_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [LIN_W+EXP_W:0]   presc_field,
  output logic                   tick,
  output logic                   sclk,
  output logic                   sclk_rise,
  output logic                   sclk_fall
);

  localparam int FIELD_W = LIN_W + EXP_W + 1;
  localparam int DIV_W   = LIN_W + (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_next;
  logic [DIV_W-1:0] div_cur;
  logic             reload_evt;

  presc_decode #(
    .ENC     (ENC),
    .LIN_W   (LIN_W),
    .EXP_W   (EXP_W),
    .FIELD_W (FIELD_W),
    .DIV_W   (DIV_W)
  ) u_dec (
    .field   (presc_field),
    .divisor (div_next)
  );

  presc_counter #(
    .DIV_W   (DIV_W),
    .RST_DIV (4)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .next_div  (div_next),
    .tick      (tick),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .div_cur   (div_cur),
    .reload    (reload_evt)
  );

endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic             sclk,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic [DIV_W-1:0] div_cur,
  input logic             reload_evt
);

  // R7: at most one edge indication at a time
  a_r7_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && sclk_fall));

  // R7: a rising indication is followed by a high serial clock
  a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sclk);

  // R7: a falling indication is followed by a low serial clock
  a_r7_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall |=> !sclk);

  // R7: without a strobe the serial clock holds while enabled
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(sclk));

  // R8: disabling drives the serial clock low
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk);

  // R9: the divisor in use changes only at a rising edge while enabled
  a_r9_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sclk_rise) |=> $stable(div_cur));

  // R9: reload event never fires mid-phase while enabled
  a_r9_reload_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reload_evt) |-> sclk_rise);

  // R6: divisor of one strobes every enabled cycle
  a_r6_div1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div_cur == DIV_W'(1)) |-> tick);

endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .tick       (tick),
  .sclk       (sclk),
  .sclk_rise  (sclk_rise),
  .sclk_fall  (sclk_fall),
  .div_cur    (div_cur),
  .reload_evt (reload_evt)
);

// File: tb/spi_sclk_prescaler_test.sv
module spi_sclk_prescaler_test;
  import spi_presc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] fe = 8'h00;
  logic [7:0] fl = 8'h10;

  logic e_tick, e_sclk, e_rise, e_fall;
  logic l_tick, l_sclk, l_rise, l_fall;

  spi_sclk_prescaler #(.ENC(ENC_EXTENDED)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .presc_field(fe),
    .tick(e_tick), .sclk(e_sclk), .sclk_rise(e_rise), .sclk_fall(e_fall));

  spi_sclk_prescaler #(.ENC(ENC_LEGACY)) uut_leg (
    .clk(clk), .rst_n(rst_n), .en(en), .presc_field(fl),
    .tick(l_tick), .sclk(l_sclk), .sclk_rise(l_rise), .sclk_fall(l_fall));

  always #4 clk = ~clk;  // 125 MHz

  int  n_chk = 0;
  int  n_fail = 0;
  int  cycles = 0;
  bit  done = 0;
  int  m_sclk [2] = '{0, 0};
  int  m_cnt  [2] = '{0, 0};
  int  m_div  [2] = '{4, 4};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Reference divisor: index 0 extended, 1 legacy
  function automatic int ref_div(input int idx, input int f);
    int d, lin, e;
    if (idx == 1) begin
      d = 2 * ((f & 31) - 16);
      if (d < 4) d = 4;
    end else begin
      lin = f & 15;
      if (lin == 0) lin = 1;
      e = ((f >> 4) & 1) + 2 * ((f >> 6) & 3);
      d = lin * (2 ** e);
    end
    return d;
  endfunction

  function automatic int plen(input int idx);
    int hi, lo;
    hi = (m_div[idx] + 1) / 2;
    lo = m_div[idx] / 2;
    if (lo == 0) lo = 1;
    return (m_sclk[idx] != 0) ? hi : lo;
  endfunction

  function automatic int field_of(input int idx);
    return (idx == 0) ? int'(fe) : int'(fl);
  endfunction

  // Reference model update and watchdog
  always @(posedge clk) begin
    cycles++;
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_sclk[i] = 0; m_cnt[i] = 0; m_div[i] = 4;
      end else if (!en) begin
        m_sclk[i] = 0; m_cnt[i] = 0; m_div[i] = ref_div(i, field_of(i));
      end else if (m_cnt[i] == plen(i) - 1) begin
        if (m_sclk[i] == 0) m_div[i] = ref_div(i, field_of(i));
        m_sclk[i] = 1 - m_sclk[i];
        m_cnt[i] = 0;
      end else begin
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (cycles == 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      finish_up();
    end
  end

  // Per-cycle comparison against the model (R7 strobe relations)
  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < 2; i++) begin
        int tk, exp_v, act_v;
        tk = (en && m_cnt[i] == plen(i) - 1) ? 1 : 0;
        exp_v = m_sclk[i] * 8 + tk * 4 + (tk & (1 - m_sclk[i])) * 2 + (tk & m_sclk[i]);
        act_v = (i == 0) ? int'({e_sclk, e_tick, e_rise, e_fall})
                         : int'({l_sclk, l_tick, l_rise, l_fall});
        check(act_v == exp_v, "R7", "model {sclk,tick,rise,fall}", act_v, exp_v);
      end
    end
  end

  function automatic logic cur(input int idx);
    return (idx == 0) ? e_sclk : l_sclk;
  endfunction

  task automatic measure(input int idx, input int ehi, input int elo, input string req);
    int hi = 0;
    int lo = 0;
    @(negedge clk);
    while (cur(idx) != 1'b0) @(negedge clk);
    while (cur(idx) == 1'b0) @(negedge clk);
    while (cur(idx) == 1'b1) begin hi++; @(negedge clk); end
    while (cur(idx) == 1'b0) begin lo++; @(negedge clk); end
    check(hi == ehi, req, "high phase cycles", hi, ehi);
    check(lo == elo, req, "low phase cycles", lo, elo);
  endtask

  task automatic set_fields(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk); #2;
    fe = a; fl = b;
  endtask

  initial begin
    int first_e, first_l, lo1, hi1, lo2;
    // R10: reset state
    repeat (2) @(negedge clk);
    check({e_sclk, e_tick, e_rise, e_fall} == 4'b0, "R10", "ext outputs in reset",
          int'({e_sclk, e_tick, e_rise, e_fall}), 0);
    check({l_sclk, l_tick, l_rise, l_fall} == 4'b0, "R10", "legacy outputs in reset",
          int'({l_sclk, l_tick, l_rise, l_fall}), 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R8: idle while disabled, then first rise after floor(D/2) cycles
    set_fields(8'h13, 8'h17);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!e_sclk && !e_tick && !l_sclk && !l_tick, "R8", "idle outputs",
            int'({e_sclk, e_tick, l_sclk, l_tick}), 0);
    end
    @(posedge clk); #2 en = 1'b1;
    first_e = 0; first_l = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (e_rise && first_e == 0) first_e = k;
      if (l_rise && first_l == 0) first_l = k;
    end
    check(first_e == 3, "R8", "ext first rise cycle", first_e, 3);
    check(first_l == 7, "R8", "legacy first rise cycle", first_l, 7);

    measure(0, 3, 3, "R3");    // 3 * 2^1 = 6
    measure(1, 7, 7, "R1");    // 2 * 7 = 14
    set_fields(8'h43, 8'h1F);
    measure(0, 6, 6, "R3");    // 3 * 2^2 = 12
    measure(1, 15, 15, "R1");  // 30
    set_fields(8'hC1, 8'h05);
    measure(0, 32, 32, "R3");  // 1 * 2^6 = 64
    measure(1, 2, 2, "R2");    // bit 4 clear -> 4
    set_fields(8'h23, 8'h11);
    measure(0, 2, 1, "R3");    // bit 5 ignored -> 3
    measure(1, 2, 2, "R2");    // k = 1 -> 4
    set_fields(8'h05, 8'h12);
    measure(0, 3, 2, "R5");    // odd 5: high gets extra cycle
    measure(1, 2, 2, "R1");    // k = 2 -> 4
    set_fields(8'h40, 8'h12);
    measure(0, 2, 2, "R4");    // factor 0 -> 1, times 4
    set_fields(8'h00, 8'h12);
    measure(0, 1, 1, "R6");    // divisor 1
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(e_tick == 1'b1, "R6", "tick every cycle", int'(e_tick), 1);
    end
    set_fields(8'hDF, 8'h12);
    measure(0, 960, 960, "R3"); // 15 * 128 = 1920

    // R9: change mid low phase; old low completes, new divisor from next rise
    set_fields(8'h13, 8'h12);
    measure(0, 3, 3, "R5");
    @(negedge clk);
    while (!e_fall) @(negedge clk);
    @(posedge clk); #2 fe = 8'h0A;
    lo1 = 0; hi1 = 0; lo2 = 0;
    @(negedge clk);
    while (!e_sclk) begin lo1++; @(negedge clk); end
    while (e_sclk) begin hi1++; @(negedge clk); end
    while (!e_sclk) begin lo2++; @(negedge clk); end
    check(lo1 == 3, "R9", "low phase in progress keeps old length", lo1, 3);
    check(hi1 == 5, "R9", "high phase after change", hi1, 5);
    check(lo2 == 5, "R9", "low phase after change", lo2, 5);

    // R8: dropping enable mid high phase
    while (!e_sclk) @(negedge clk);
    @(posedge clk); #2 en = 1'b0;
    @(negedge clk);
    check(!e_tick && !e_rise && !e_fall, "R8", "strobes off when disabled",
          int'({e_tick, e_rise, e_fall}), 0);
    @(negedge clk);
    check(!e_sclk, "R8", "sclk low after disable", int'(e_sclk), 0);
    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule